// File: doc/BRIEF.md
# Debug Trace Buffer with Locked Readout

This block is a circular store for program-flow trace lines. While a debug session is armed, each capture pulse writes one line: a 4-bit flag field and a 32-bit address payload. After the session the host reads the lines back through a single 16-bit register port, oldest line first. Each line comes out as three consecutive words, with the flag word first.

Reads are protected. Arming locks the buffer, and only an aligned word write made while disarmed unlocks it. A read returns data and moves the read position only when all of these hold: the module is disarmed, trace-source mode is on, the system is not secured, and the access is an aligned word. Every other read returns zero and leaves the read position where it was.

The stored lines, the write position, the wrap flag and the line counter have no reset. A session captured before a system reset can therefore still be unlocked and read afterwards. A new session, marked by the rising edge of arm, clears the counter and the wrap flag and starts writing at line 0.

Top module: `trc_tbuf`

## Requirements
- R1: After reset the buffer is locked, and every read returns 0 until an unlock write is made.
- R2: While `arm` is high, a read returns 0 and does not move the read position. After `arm` falls the buffer stays locked until it is unlocked.
- R3: The buffer is unlocked only by a write with `host_word`=1 and `host_addr0`=0 while `arm` is low. Byte writes (`host_word`=0) and misaligned writes (`host_addr0`=1) leave it locked.
- R4: A read with `host_word`=0 or `host_addr0`=1 returns 0 and does not move the read position.
- R5: A read while `tsrc_en` is low or `secure` is high returns 0 and does not move the read position.
- R6: Each line is read as three words in this order. Word 0 is {12'b0, flags[3:0]}. Word 1 is payload[15:0]. Word 2 is payload[31:16]. The read position moves to the next line only after word 2 has been read.
- R7: Lines are read in capture order. Without a wrap, the first line read is line 0. After a wrap, the first line read is the oldest line, which is the slot the next capture would overwrite.
- R8: Any write with `host_addr0`=0, byte or word, moves the read position back to word 0 of the oldest line.
- R9: `line_count` counts the lines captured in the session and stops at DEPTH (default 64). Reads do not change it. `wrapped` is set by the capture that fills the last slot.
- R10: The stored lines, `line_count` and `wrapped` keep their values through a reset, and the lines can be read after an unlock.
- R11: Flag bit 3 marks a destination address, bit 2 marks a vector, and bits 1:0 hold program-counter bits 17:16. A line captured with bit 2 set reads back with bit 3 set.
- R12: A rising edge of `arm` starts a session: it clears `line_count` and `wrapped` and resets the write position to line 0. A capture is accepted only when `arm` is high in that cycle and was also high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Session armed level |
| tsrc_en | input | 1 | Trace-source mode enable |
| secure | input | 1 | System secured; blocks readout |
| cap_valid | input | 1 | One-cycle capture strobe |
| cap_info | input | 4 | Flag field: {dest, vector, pc[17:16]} |
| cap_data | input | 32 | Captured address payload |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_word | input | 1 | 1 = word access, 0 = byte access |
| host_addr0 | input | 1 | Byte offset of the access; 0 = aligned |
| rd_data | output | 16 | Read word (zero when the read is not allowed) |
| line_count | output | 7 | Valid lines in the session |
| wrapped | output | 1 | Set once the buffer has wrapped |

## Verification
The assertions check, on every cycle, the rules that hold whatever the data: reads are zeroed while armed, for bad accesses and while trace-source mode is off; the read position holds while armed; the counter holds while disarmed and never passes the depth; the wrap flag implies a full counter; the lock falls only after a valid unlock write; and a vector flag always reads back with its destination flag. Only the bench scenarios can show the data itself. They check the oldest-first order before and after a wrap, the three-word line layout, the restart of an interrupted readout, the session started by arm, and the lines and counter that survive a reset.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int WORD_W = 16;
  localparam int INFO_W = 4;

  // Flag field of one trace line; vec implies dst
  typedef struct packed {
    logic       dst;
    logic       vec;
    logic [1:0] pc_hi;
  } trc_info_t;

  // Access class of a host strobe
  typedef enum logic [1:0] {
    ACC_NONE    = 2'd0,
    ACC_ALIGNED = 2'd1,
    ACC_BAD     = 2'd2
  } acc_e;
endpackage

// File: rtl/trc_rst_sync.sv
module trc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/trc_store.sv
module trc_store
  import trc_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int LW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int LINE_W = INFO_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              arm,
  input  logic              cap_valid,
  input  trc_info_t         cap_info,
  input  logic [DATA_W-1:0] cap_data,
  input  logic [LW-1:0]     rd_line,
  output trc_info_t         rd_info,
  output logic [DATA_W-1:0] rd_dat,
  output logic [LW-1:0]     wr_ptr,
  output logic [CW-1:0]     line_count,
  output logic              wrapped
);
  logic              arm_q;
  logic              arm_rise;
  logic              cap_ok;
  logic [LW-1:0]     wp_q, wp_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              wrap_q, wrap_d;
  logic              last_slot;
  trc_info_t         info_fix;
  logic [LINE_W-1:0] mem [DEPTH];
  logic [LINE_W-1:0] rd_word_line;

  // arm history register: the only reset state in this unit
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) arm_q <= 1'b0;
    else         arm_q <= arm;
  end

  assign arm_rise  = rst_sn & arm & ~arm_q;
  assign cap_ok    = rst_sn & cap_valid & arm & arm_q;
  assign last_slot = (wp_q == LW'(DEPTH - 1));

  // vector addresses are always destinations
  always_comb begin
    info_fix     = cap_info;
    info_fix.dst = cap_info.dst | cap_info.vec;
  end

  always_comb begin
    wp_d   = wp_q;
    cnt_d  = cnt_q;
    wrap_d = wrap_q;
    if (arm_rise) begin
      wp_d   = '0;
      cnt_d  = '0;
      wrap_d = 1'b0;
    end else if (cap_ok) begin
      wp_d = last_slot ? '0 : wp_q + 1'b1;
      if (cnt_q != CW'(DEPTH)) cnt_d = cnt_q + 1'b1;
      if (last_slot)           wrap_d = 1'b1;
    end
  end

  // session state survives reset on purpose: no reset branch
  always_ff @(posedge clk) begin
    if (arm_rise || cap_ok) begin
      wp_q   <= wp_d;
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_ok) mem[wp_q] <= {info_fix, cap_data};
  end

  assign rd_word_line = mem[rd_line];
  assign rd_info      = trc_info_t'(rd_word_line[LINE_W-1 -: INFO_W]);
  assign rd_dat       = rd_word_line[DATA_W-1:0];
  assign wr_ptr       = wp_q;
  assign line_count   = cnt_q;
  assign wrapped      = wrap_q;
endmodule

// File: rtl/trc_lock.sv
module trc_lock (
  input  logic clk,
  input  logic rst_sn,
  input  logic arm,
  input  logic unlock_req,
  output logic locked
);
  logic lk_q, lk_d;

  always_comb begin
    lk_d = lk_q;
    if (arm)             lk_d = 1'b1;
    else if (unlock_req) lk_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) lk_q <= 1'b1;
    else         lk_q <= lk_d;
  end

  assign locked = lk_q;
endmodule

// File: rtl/trc_rdptr.sv
module trc_rdptr #(
  parameter int DEPTH = 64,
  parameter int NSLOT = 3,
  localparam int LW   = $clog2(DEPTH),
  localparam int SW   = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          rehome,
  input  logic          advance,
  input  logic [LW-1:0] home_line,
  output logic [LW-1:0] rd_line,
  output logic [SW-1:0] rd_slot
);
  logic [LW-1:0] line_q, line_d;
  logic [SW-1:0] slot_q, slot_d;
  logic          end_of_line;
  logic          ptr_en;

  assign end_of_line = (slot_q == SW'(NSLOT - 1));
  assign ptr_en      = rehome | advance;

  always_comb begin
    line_d = line_q;
    slot_d = slot_q;
    if (rehome) begin
      line_d = home_line;
      slot_d = '0;
    end else if (advance) begin
      if (end_of_line) begin
        slot_d = '0;
        line_d = (line_q == LW'(DEPTH - 1)) ? '0 : line_q + 1'b1;
      end else begin
        slot_d = slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      line_q <= '0;
      slot_q <= '0;
    end else if (ptr_en) begin
      line_q <= line_d;
      slot_q <= slot_d;
    end
  end

  assign rd_line = line_q;
  assign rd_slot = slot_q;
endmodule

// File: rtl/trc_tbuf.sv
module trc_tbuf
  import trc_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int LW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int DSLOT = DATA_W / WORD_W,
  localparam int NSLOT = DSLOT + 1,
  localparam int SW    = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              tsrc_en,
  input  logic              secure,
  input  logic              cap_valid,
  input  logic [3:0]        cap_info,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_word,
  input  logic              host_addr0,
  output logic [WORD_W-1:0] rd_data,
  output logic [CW-1:0]     line_count,
  output logic              wrapped
);
  logic              rst_sn;
  logic              locked;
  logic              unlock_req;
  logic              rehome;
  logic              rd_legal;
  acc_e              rd_acc;
  logic [LW-1:0]     rd_line;
  logic [SW-1:0]     rd_slot;
  logic [LW-1:0]     wr_ptr;
  logic [LW-1:0]     home_line;
  trc_info_t         line_info;
  logic [DATA_W-1:0] line_dat;
  logic [WORD_W-1:0] slot_word [NSLOT];
  logic [WORD_W-1:0] sel_word;

  trc_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  trc_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .arm        (arm),
    .cap_valid  (cap_valid),
    .cap_info   (trc_info_t'(cap_info)),
    .cap_data   (cap_data),
    .rd_line    (rd_line),
    .rd_info    (line_info),
    .rd_dat     (line_dat),
    .wr_ptr     (wr_ptr),
    .line_count (line_count),
    .wrapped    (wrapped)
  );

  // host access classification
  always_comb begin
    if (!host_rd)                     rd_acc = ACC_NONE;
    else if (host_word && !host_addr0) rd_acc = ACC_ALIGNED;
    else                              rd_acc = ACC_BAD;
  end

  assign unlock_req = host_wr & host_word & ~host_addr0 & ~arm;
  assign rehome     = host_wr & ~host_addr0;
  assign rd_legal   = (rd_acc == ACC_ALIGNED) & ~arm & ~locked & tsrc_en & ~secure;
  assign home_line  = wrapped ? wr_ptr : '0;

  trc_lock u_lock (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .arm        (arm),
    .unlock_req (unlock_req),
    .locked     (locked)
  );

  trc_rdptr #(.DEPTH(DEPTH), .NSLOT(NSLOT)) u_rdptr (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .rehome    (rehome),
    .advance   (rd_legal & ~rehome),
    .home_line (home_line),
    .rd_line   (rd_line),
    .rd_slot   (rd_slot)
  );

  // slot 0 carries the flag field, the rest carry the payload low-first
  assign slot_word[0] = {{(WORD_W - INFO_W){1'b0}}, line_info};
  for (genvar k = 1; k < NSLOT; k++) begin : g_slot
    assign slot_word[k] = line_dat[k*WORD_W-1 -: WORD_W];
  end

  always_comb begin
    sel_word = '0;
    for (int k = 0; k < NSLOT; k++) begin
      if (rd_slot == SW'(k)) sel_word = slot_word[k];
    end
  end

  assign rd_data = rd_legal ? sel_word : '0;
endmodule

// File: rtl/trc_tbuf_chk.sv
module trc_tbuf_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7,
  parameter int LW    = 6,
  parameter int SW    = 2
) (
  input logic          clk,
  input logic          rst_sn,
  input logic          arm,
  input logic          tsrc_en,
  input logic          host_rd,
  input logic          host_wr,
  input logic          host_word,
  input logic          host_addr0,
  input logic [15:0]   rd_data,
  input logic [CW-1:0] line_count,
  input logic          wrapped,
  input logic          locked,
  input logic [LW-1:0] rd_line,
  input logic [SW-1:0] rd_slot
);
  p_armed_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (arm && host_rd) |-> (rd_data == 16'h0));

  p_armed_no_advance_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (arm && !host_wr) |=> ($stable(rd_line) && $stable(rd_slot)));

  p_lock_after_arm_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    arm |=> locked);

  p_unlock_source_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(locked) |-> $past(host_wr && host_word && !host_addr0 && !arm));

  p_bad_access_zero_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (host_rd && (!host_word || host_addr0)) |-> (rd_data == 16'h0));

  p_tsrc_off_zero_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (host_rd && !tsrc_en) |-> (rd_data == 16'h0));

  p_flag_word_upper_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_slot == '0) |-> (rd_data[15:4] == 12'h0));

  p_rehome_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (host_wr && !host_addr0) |=> (rd_slot == '0));

  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    line_count <= CW'(DEPTH));

  p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    !arm |=> $stable(line_count));

  p_wrap_full_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    wrapped |-> (line_count == CW'(DEPTH)));

  p_vector_dest_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    ((rd_slot == '0) && rd_data[2]) |-> rd_data[3]);
endmodule

bind trc_tbuf trc_tbuf_chk #(.DEPTH(DEPTH), .CW(CW), .LW(LW), .SW(SW)) u_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .arm        (arm),
  .tsrc_en    (tsrc_en),
  .host_rd    (host_rd),
  .host_wr    (host_wr),
  .host_word  (host_word),
  .host_addr0 (host_addr0),
  .rd_data    (rd_data),
  .line_count (line_count),
  .wrapped    (wrapped),
  .locked     (locked),
  .rd_line    (rd_line),
  .rd_slot    (rd_slot)
);

// File: tb/test_trc_tbuf.sv
module test_trc_tbuf;
  localparam int DEPTH = 64;

  logic        clk;
  logic        rst_n;
  logic        arm, tsrc_en, secure;
  logic        cap_valid;
  logic [3:0]  cap_info;
  logic [31:0] cap_data;
  logic        host_rd, host_wr, host_word, host_addr0;
  logic [15:0] rd_data;
  logic [6:0]  line_count;
  logic        wrapped;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  logic [3:0]  m_info [DEPTH];
  logic [31:0] m_data [DEPTH];
  int m_wp, m_cnt;
  bit m_wrap;

  trc_tbuf i_trc_tbuf (
    .clk(clk), .rst_n(rst_n), .arm(arm), .tsrc_en(tsrc_en), .secure(secure),
    .cap_valid(cap_valid), .cap_info(cap_info), .cap_data(cap_data),
    .host_rd(host_rd), .host_wr(host_wr), .host_word(host_word),
    .host_addr0(host_addr0), .rd_data(rd_data), .line_count(line_count),
    .wrapped(wrapped)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [15:0] exp_word(input int line, input int slot);
    case (slot)
      0:       return {12'h000, m_info[line]};
      1:       return m_data[line][15:0];
      default: return m_data[line][31:16];
    endcase
  endfunction

  function automatic int oldest();
    return m_wrap ? m_wp : 0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic start_session();
    arm = 1'b1;
    @(negedge clk);
    m_wp = 0; m_cnt = 0; m_wrap = 0;
  endtask

  task automatic end_session();
    arm = 1'b0;
    @(negedge clk);
  endtask

  task automatic capture(input logic [3:0] inf, input logic [31:0] dat);
    cap_valid = 1'b1; cap_info = inf; cap_data = dat;
    @(negedge clk);
    cap_valid = 1'b0;
    m_info[m_wp] = {inf[3] | inf[2], inf[2:0]};
    m_data[m_wp] = dat;
    if (m_wp == DEPTH - 1) m_wrap = 1;
    m_wp = (m_wp + 1) % DEPTH;
    if (m_cnt < DEPTH) m_cnt++;
  endtask

  task automatic hwrite(input logic word, input logic a0);
    host_wr = 1'b1; host_word = word; host_addr0 = a0;
    @(negedge clk);
    host_wr = 1'b0; host_word = 1'b1; host_addr0 = 1'b0;
  endtask

  task automatic hread(input logic word, input logic a0, output logic [15:0] v);
    host_rd = 1'b1; host_word = word; host_addr0 = a0;
    #1 v = rd_data;
    @(negedge clk);
    host_rd = 1'b0; host_word = 1'b1; host_addr0 = 1'b0;
  endtask

  task automatic read_line(input string req, input int line);
    logic [15:0] v;
    for (int s = 0; s < 3; s++) begin
      hread(1'b1, 1'b0, v);
      check(req, v, exp_word(line, s));
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int n;
    process::self().srandom(32'd2024);
    arm = 0; tsrc_en = 1; secure = 0; cap_valid = 0; cap_info = 0; cap_data = 0;
    host_rd = 0; host_wr = 0; host_word = 1; host_addr0 = 0; rst_n = 1;
    #2;
    do_reset();

    // R1: locked after reset
    hread(1'b1, 1'b0, v);
    check("R1 locked after reset", v, 16'h0);

    // short session with a vector-only flag line
    start_session();
    capture(4'h3, 32'hA1B2_C3D4);
    capture(4'h8, 32'h1111_2222);
    capture(4'h4, 32'h3333_4444);   // R11: vector without destination
    capture(4'hE, $urandom);
    capture(4'h1, $urandom);
    check("R9 count after 5", line_count, 5);
    check("R9 no wrap", wrapped, 0);
    hread(1'b1, 1'b0, v);
    check("R2 read while armed", v, 16'h0);
    end_session();
    hread(1'b1, 1'b0, v);
    check("R2 still locked after disarm", v, 16'h0);
    hwrite(1'b0, 1'b0);
    hread(1'b1, 1'b0, v);
    check("R3 byte write does not unlock", v, 16'h0);
    hwrite(1'b1, 1'b1);
    hread(1'b1, 1'b0, v);
    check("R3 misaligned write does not unlock", v, 16'h0);
    hwrite(1'b1, 1'b0);

    // R7 no wrap starts at line 0; R4/R5 interleaved bad reads
    hread(1'b1, 1'b0, v);
    check("R7 first word line0", v, exp_word(0, 0));
    hread(1'b0, 1'b0, v);
    check("R4 byte read zero", v, 16'h0);
    hread(1'b1, 1'b1, v);
    check("R4 misaligned read zero", v, 16'h0);
    tsrc_en = 0;
    hread(1'b1, 1'b0, v);
    check("R5 trace-source off", v, 16'h0);
    tsrc_en = 1; secure = 1;
    hread(1'b1, 1'b0, v);
    check("R5 secured", v, 16'h0);
    secure = 0;
    hread(1'b1, 1'b0, v);
    check("R4 R5 pointer held", v, exp_word(0, 1));
    hread(1'b1, 1'b0, v);
    check("R6 word2 line0", v, exp_word(0, 2));
    for (int l = 1; l < 5; l++) read_line("R6 R7 line order", l);
    check("R11 vector implies dest", exp_word(2, 0), 16'h000C);
    check("R9 count stable after reads", line_count, 5);

    // R8 restart an interrupted readout
    hwrite(1'b1, 1'b0);
    repeat (4) hread(1'b1, 1'b0, v);
    hwrite(1'b1, 1'b0);
    hread(1'b1, 1'b0, v);
    check("R8 word write re-homes", v, exp_word(0, 0));
    hread(1'b1, 1'b0, v);
    hwrite(1'b0, 1'b0);
    hread(1'b1, 1'b0, v);
    check("R8 byte write re-homes", v, exp_word(0, 0));

    // R12 capture in arm-rise cycle and while disarmed are ignored
    arm = 1; cap_valid = 1; cap_info = 4'h2; cap_data = 32'hDEAD_BEEF;
    @(negedge clk);
    cap_valid = 0;
    m_wp = 0; m_cnt = 0; m_wrap = 0;
    check("R12 arm-rise capture ignored", line_count, 0);
    capture(4'h9, 32'h0BAD_F00D);
    end_session();
    cap_valid = 1; cap_info = 4'h1; cap_data = 32'h5555_AAAA;
    @(negedge clk);
    cap_valid = 0;
    check("R12 disarmed capture ignored", line_count, 1);
    hwrite(1'b1, 1'b0);
    read_line("R12 first accepted line", 0);

    // wrap session
    start_session();
    for (int i = 0; i < 70; i++) capture(4'($urandom), $urandom);
    end_session();
    check("R9 count saturates", line_count, DEPTH);
    check("R9 wrapped set", wrapped, 1);
    hwrite(1'b1, 1'b0);
    for (int l = 0; l < DEPTH; l++) read_line("R7 oldest first after wrap", (oldest() + l) % DEPTH);

    // R10 reset keeps session
    hwrite(1'b1, 1'b0);
    read_line("R7 before reset", oldest());
    do_reset();
    check("R10 count kept", line_count, DEPTH);
    check("R10 wrap kept", wrapped, 1);
    hread(1'b1, 1'b0, v);
    check("R10 R1 locked after reset", v, 16'h0);
    hwrite(1'b1, 1'b0);
    read_line("R10 data kept", oldest());
    read_line("R10 data kept", (oldest() + 1) % DEPTH);

    // random sessions
    for (int sess = 0; sess < 6; sess++) begin
      n = 1 + int'($urandom % 90);
      start_session();
      for (int i = 0; i < n; i++) begin
        if ($urandom % 4 == 0) @(negedge clk);
        capture(4'($urandom), $urandom);
      end
      end_session();
      check("R9 random count", line_count, m_cnt);
      check("R9 random wrap", wrapped, m_wrap);
      hwrite(1'b1, 1'b0);
      for (int l = 0; l < m_cnt; l++) begin
        for (int s = 0; s < 3; s++) begin
          if ($urandom % 5 == 0) begin
            hread(1'b0, 1'($urandom), v);
            check("R4 random bad read", v, 16'h0);
          end
          hread(1'b1, 1'b0, v);
          check("R6 R7 random readout", v, exp_word((oldest() + l) % DEPTH, s));
        end
      end
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule